// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides, on the receive side of an Ethernet MAC, whether a frame should be kept, based only on its destination address. The six destination bytes arrive one per valid cycle, the first one flagged as start of frame. While they stream in, the block runs an Ethernet CRC-32 over them. Seven bits of that CRC index a 128-bit hash table, which is held as four 32-bit words. A multicast destination is kept when the indexed table bit is set.

Unicast destinations are compared against a programmed station address. Broadcast is always kept. An all-multicast control and a hash enable let every multicast frame through. Software loads the table words and the station address through a one-cycle register write port. A power-down flag freezes both.

One cycle after the sixth address byte, the block raises a single-cycle valid strobe together with the accept decision. Bytes beyond the sixth are ignored until the next start of frame.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash index is bits 29 down to 23 of a CRC-32 over the six destination bytes. The CRC uses polynomial 0x04C11DB7 in a most-significant-bit-first register that starts at all ones, with no final inversion. Each byte is fed least significant bit first, and the first received byte goes first.
- R2: The index selects table word index/32, where reg_sel 0 is the word for indices 0 to 31 and reg_sel 3 the word for 96 to 127. Within that word it selects bit index mod 32.
- R3: A destination is multicast when bit 0 of its first byte is 1. With hash_en high and all_mcast low, a non-broadcast multicast frame is accepted exactly when the indexed table bit is 1.
- R4: With all_mcast high or hash_en low, every multicast frame is accepted.
- R5: The broadcast address FF:FF:FF:FF:FF:FF is always accepted.
- R6: With uni_en high, a unicast frame is accepted exactly when its destination equals the station address. The station address is held in two registers:
  - reg_sel 4: first byte in bits 15:8 and second byte in bits 7:0.
  - reg_sel 5: third byte in bits 31:24 down to sixth byte in bits 7:0.
- R7: While uni_en is low, every unicast frame is accepted and the station address is held at zero. Station writes made in that time have no effect.
- R8: While coma is high, register writes to the table words and to the station address are ignored.
- R9: dec_valid is high for exactly one cycle, the cycle after the sixth byte following a start of frame is taken. The following are not counted as address bytes:
  - cycles with byte_valid low;
  - bytes before any start of frame;
  - bytes after the sixth.
  A start of frame in the middle of an address restarts collection.
- R10: After reset, dec_valid and dec_accept are 0, all table bits are 0 and the station address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | byte_data holds a received byte |
| byte_sof | input | 1 | This byte is the first destination byte |
| byte_data | input | 8 | Received byte |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0-3 table words, 4 station high, 5 station low |
| reg_wdata | input | 32 | Register write data |
| coma | input | 1 | Power-down flag; blocks register writes |
| uni_en | input | 1 | Unicast station-address filter enable |
| hash_en | input | 1 | Multicast hash filter enable |
| all_mcast | input | 1 | Accept every multicast frame |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame kept (meaningful with dec_valid) |

## Verification
The bench uses a single set table bit, computed from an independently written reflected CRC, then moves that bit to its neighbour. A design that took the wrong CRC bits, reversed the bit order or mapped the index into the wrong word would accept the frame with the neighbouring bit or reject the frame with the correct one.

Writes made while coma is high, or made to the station address while uni_en is low, are followed by frames that would only be accepted if those writes had taken effect. A design that leaked such writes would accept those frames.

Restarts in the middle of an address, gaps, stray bytes before a start of frame and trailing bytes are streamed as well. A design with a miscounted byte counter would strobe early, strobe twice or decide on the wrong address.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 32,
  parameter int SEL_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic              byte_sof,
  input  logic [7:0]        byte_data,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              coma,
  input  logic              uni_en,
  input  logic              hash_en,
  input  logic              all_mcast,
  output logic              dec_valid,
  output logic              dec_accept
);
  localparam int          ADDR_BYTES = 6;
  localparam int          ADDR_W     = 8 * ADDR_BYTES;
  localparam int          TABLE_BITS = NUM_WORDS * WORD_W;
  localparam int          IDX_W      = $clog2(TABLE_BITS);
  localparam int          IDX_TOP    = 29;
  localparam int          CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam int          HI_W       = ADDR_W - 32;
  localparam int          SEL_HI     = NUM_WORDS;
  localparam int          SEL_LO     = NUM_WORDS + 1;
  localparam logic [31:0] POLY       = 32'h04C11DB7;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ d[i]) ? POLY : 32'h0);
    return r;
  endfunction

  logic [WORD_W-1:0]     hash_w [NUM_WORDS];
  logic [TABLE_BITS-1:0] hash_flat;
  logic [HI_W-1:0]       st_hi;
  logic [31:0]           st_lo;
  logic [31:0]           crc_q;
  logic [ADDR_W-9:0]     addr_q;
  logic [CNT_W-1:0]      cnt_q;

  wire wr_ok      = reg_we && !coma;
  wire take_first = byte_valid && byte_sof;
  wire take_next  = byte_valid && !byte_sof && (cnt_q != '0);
  wire last_byte  = take_next && (cnt_q == CNT_W'(ADDR_BYTES - 1));

  wire [31:0]       crc_nx  = crc_byte(take_first ? 32'hFFFF_FFFF : crc_q, byte_data);
  wire [ADDR_W-1:0] addr_nx = {addr_q, byte_data};
  wire [IDX_W-1:0]  idx     = crc_nx[IDX_TOP -: IDX_W];
  wire              is_mc   = addr_nx[ADDR_W-8];
  wire              is_bc   = &addr_nx;
  wire              hit     = hash_flat[idx];
  wire              st_eq   = addr_nx == {st_hi, st_lo};
  wire              verdict = is_bc || (is_mc ? (all_mcast || !hash_en || hit)
                                              : (!uni_en || st_eq));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                               hash_w[w] <= '0;
      else if (wr_ok && reg_sel == SEL_W'(w))   hash_w[w] <= reg_wdata;
    assign hash_flat[w*WORD_W +: WORD_W] = hash_w[w];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_hi <= '0;
      st_lo <= '0;
    end else if (!uni_en) begin
      st_hi <= '0;
      st_lo <= '0;
    end else if (wr_ok) begin
      if (reg_sel == SEL_W'(SEL_HI)) st_hi <= reg_wdata[HI_W-1:0];
      if (reg_sel == SEL_W'(SEL_LO)) st_lo <= reg_wdata[31:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      crc_q      <= '1;
      addr_q     <= '0;
      cnt_q      <= '0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      if (take_first || take_next) begin
        crc_q  <= crc_nx;
        addr_q <= addr_nx[ADDR_W-9:0];
      end
      if (take_first)      cnt_q <= CNT_W'(1);
      else if (last_byte)  cnt_q <= '0;
      else if (take_next)  cnt_q <= cnt_q + CNT_W'(1);
      dec_valid  <= last_byte;
      dec_accept <= last_byte && verdict;
    end
endmodule

// File: rtl/mcast_hash_filter_chk.sv
module mcast_hash_filter_chk #(
  parameter int TABLE_BITS = 128,
  parameter int ADDR_W     = 48
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  byte_valid,
  input logic [7:0]            byte_data,
  input logic                  coma,
  input logic                  uni_en,
  input logic                  all_mcast,
  input logic                  dec_valid,
  input logic                  dec_accept,
  input logic [TABLE_BITS-1:0] hash_bits,
  input logic [ADDR_W-1:0]     station
);
  logic [ADDR_W-1:0] seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          seen <= '0;
    else if (byte_valid) seen <= {seen[ADDR_W-9:0], byte_data};

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  p_strobe_after_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(byte_valid));
  p_accept_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept);
  p_coma_table_r8: assert property (@(posedge clk) disable iff (!rst_n)
    coma |=> $stable(hash_bits));
  p_coma_station_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (coma && uni_en) |=> $stable(station));
  p_station_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !uni_en |=> station == '0);
  p_bcast_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && (&seen)) |-> dec_accept);
  p_allmc_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && seen[ADDR_W-8] && $past(all_mcast)) |-> dec_accept);
endmodule

bind mcast_hash_filter mcast_hash_filter_chk #(
  .TABLE_BITS(TABLE_BITS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
  .coma(coma), .uni_en(uni_en), .all_mcast(all_mcast),
  .dec_valid(dec_valid), .dec_accept(dec_accept),
  .hash_bits(hash_flat), .station({st_hi, st_lo})
);

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        byte_valid = 0, byte_sof = 0;
  logic [7:0]  byte_data = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic        coma = 0, uni_en = 1, hash_en = 1, all_mcast = 0;
  logic        dec_valid, dec_accept;

  int    checks = 0, errors = 0;
  bit    done = 0;
  string cur_req = "R10";

  always #10 clk = ~clk;

  mcast_hash_filter dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_sof(byte_sof),
    .byte_data(byte_data), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .coma(coma), .uni_en(uni_en), .hash_en(hash_en), .all_mcast(all_mcast),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  function automatic bit [6:0] ref_index(input bit [47:0] a);
    bit [31:0] c = 32'hFFFF_FFFF;
    bit [31:0] r;
    for (int i = 0; i < 6; i++) begin
      c ^= {24'h0, a[47-8*i -: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    for (int k = 0; k < 32; k++) r[k] = c[31-k];
    return r[29:23];
  endfunction

  bit [31:0] m_hash [4];
  bit [47:0] m_st;
  bit [7:0]  m_q [$];
  bit        m_valid, m_acc;

  function automatic bit ref_decide(input bit [47:0] a);
    int ix;
    if (a == 48'hFFFF_FFFF_FFFF) return 1;
    if (a[40]) begin
      if (all_mcast || !hash_en) return 1;
      ix = int'(ref_index(a));
      return m_hash[ix / 32][ix % 32];
    end
    return !uni_en || (a == m_st);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_hash[i]) m_hash[i] = 0;
      m_st = 0; m_q = {}; m_valid = 0; m_acc = 0;
    end else begin
      bit [47:0] a;
      m_valid = 0; m_acc = 0;
      if (byte_valid && byte_sof) begin
        m_q = {}; m_q.push_back(byte_data);
      end else if (byte_valid && m_q.size() > 0 && m_q.size() < 6) begin
        m_q.push_back(byte_data);
        if (m_q.size() == 6) begin
          for (int i = 0; i < 6; i++) a[47-8*i -: 8] = m_q[i];
          m_valid = 1; m_acc = ref_decide(a);
        end
      end
      if (reg_we && !coma && reg_sel < 4) m_hash[reg_sel] = reg_wdata;
      if (!uni_en) m_st = 0;
      else if (reg_we && !coma && reg_sel == 4) m_st[47:32] = reg_wdata[15:0];
      else if (reg_we && !coma && reg_sel == 5) m_st[31:0] = reg_wdata;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    if (!rst_n) begin
      check("R10", "dec_valid in reset", dec_valid, 0);
      check("R10", "dec_accept in reset", dec_accept, 0);
    end else begin
      check("R9", "dec_valid vs model", dec_valid, m_valid);
      if (m_valid) check(cur_req, "dec_accept vs model", dec_accept, m_acc);
    end
  end

  task automatic drive(input bit v, input bit s, input bit [7:0] d);
    byte_valid = v; byte_sof = s; byte_data = d;
    @(negedge clk);
    byte_valid = 0; byte_sof = 0;
  endtask

  task automatic send(input bit [47:0] a, input bit exp, input string req);
    cur_req = req;
    for (int i = 0; i < 6; i++) begin
      byte_valid = 1; byte_sof = (i == 0); byte_data = a[47-8*i -: 8];
      @(negedge clk);
    end
    byte_valid = 0; byte_sof = 0;
    check(req, "strobe after sixth byte", dec_valid, 1);
    check(req, "directed decision", dec_accept, exp);
    @(negedge clk);
  endtask

  task automatic wr(input bit [2:0] s, input bit [31:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [47:0] mc [4] = '{48'h01005E000001, 48'h333300000001, 48'h0180C2000000, 48'hAB1234567891};
    bit [47:0] a;
    bit [31:0] seed = 32'h1234_5678;
    int ix;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: empty table rejects multicast, zero station matches zero address
    send(48'h01005E000001, 0, "R10");
    send(48'h000000000000, 1, "R10");
    // R1 / R2: single table bit at the computed index, then its neighbour
    foreach (mc[j]) begin
      ix = int'(ref_index(mc[j]));
      wr(3'(ix / 32), 32'h1 << (ix % 32));
      send(mc[j], 1, "R1");
      wr(3'(ix / 32), 32'h1 << ((ix % 32) ^ 1));
      send(mc[j], 0, "R2");
      wr(3'(ix / 32), 32'h0);
    end
    // R3: patterned table and varied multicast addresses
    wr(0, 32'hA5A5_0F0F); wr(1, 32'h3C3C_F00F); wr(2, 32'h0123_4567); wr(3, 32'hFEDC_BA98);
    for (int j = 0; j < 16; j++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      a = {seed, seed[15:0] ^ 16'h5A5A};
      a[40] = 1;
      send(a, ref_decide(a), "R3");
    end
    wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0);
    // R4: bypasses
    all_mcast = 1; send(48'h01005E7F0001, 1, "R4");
    all_mcast = 0; hash_en = 0; send(48'h01005E7F0002, 1, "R4");
    hash_en = 1; send(48'h01005E7F0002, 0, "R4");
    // R5: broadcast with empty table
    send(48'hFFFF_FFFF_FFFF, 1, "R5");
    // R6: station compare
    wr(4, 32'h0000_1A2B); wr(5, 32'h3C4D_5E60);
    send(48'h1A2B3C4D5E60, 1, "R6");
    send(48'h1A2B3C4D5E61, 0, "R6");
    send(48'h1C2B3C4D5E60, 0, "R6");
    // R7: disabled unicast filter clears station, ignores writes
    uni_en = 0; @(negedge clk);
    send(48'h1C2B3C4D5E61, 1, "R7");
    wr(4, 32'h0000_2244); wr(5, 32'h6688_AACC);
    uni_en = 1; @(negedge clk);
    send(48'h1A2B3C4D5E60, 0, "R7");
    send(48'h22446688AACC, 0, "R7");
    send(48'h000000000000, 1, "R7");
    // R8: writes ignored during coma
    coma = 1;
    wr(0, '1); wr(1, '1); wr(2, '1); wr(3, '1);
    wr(4, 32'h0000_0A0B); wr(5, 32'h0C0D_0E0F);
    coma = 0; @(negedge clk);
    send(48'h01005E000001, 0, "R8");
    send(48'h333300000001, 0, "R8");
    send(48'h0A0B0C0D0E0F, 0, "R8");
    // R9: stray bytes, restart, gaps, trailing bytes
    cur_req = "R9";
    wr(4, 32'h0000_0A0B); wr(5, 32'h0C0D_0E0F);
    drive(1, 0, 8'h0A); drive(1, 0, 8'h0B);
    check("R9", "no strobe on stray bytes", dec_valid, 0);
    drive(1, 1, 8'h77); drive(1, 0, 8'h88); drive(1, 0, 8'h99);
    drive(1, 1, 8'h0A); drive(0, 0, 8'hFF); drive(1, 0, 8'h0B); drive(1, 0, 8'h0C);
    drive(0, 0, 8'h00); drive(1, 0, 8'h0D); drive(1, 0, 8'h0E);
    drive(1, 0, 8'h0F);
    check("R9", "strobe after restart and gaps", dec_valid, 1);
    check("R9", "decision uses restarted address", dec_accept, 1);
    drive(1, 0, 8'h11); drive(1, 0, 8'h22); drive(1, 0, 8'h33);
    drive(1, 0, 8'h44); drive(1, 0, 8'h55); drive(1, 0, 8'h66);
    check("R9", "trailing bytes give no strobe", dec_valid, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule